// File: doc/BRIEF.md
# NAND Sector Parity Accumulator

This block watches the data bus of a NAND flash port and builds a 24-bit Hamming-style parity code for one 512-byte sector while the data streams past. It needs no extra bus cycles: every beat that is strobed with the configured chip select and arrives while the engine is enabled is split into bytes. Each byte is then folded into two complementary 12-bit parity fields. A data bit's 12-bit address is its byte index in the sector followed by its bit position in the byte.

Firmware sets the chip-select number, the bus-width flag and the enable bit. It pulses clear before each sector. After 512 bytes the block raises a done flag and ignores further traffic. The firmware then reads the packed 32-bit result word, or the 3-byte code built from it, and compares it with the code stored in the spare area.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset, result, code, done and the result pointer are all zero.
- R2: A clear pulse empties both parity fields, the byte count and done, and sets the result pointer to 1 on the next cycle. A beat in the same cycle as clear is dropped.
- R3: A beat counts only when enable is 1, valid is 1 and bus_cs equals cfg_cs (3 bits). Any other beat leaves the result and the count unchanged.
- R4: For every data bit equal to 1, with address A = {byte_index[8:0], bit_index[2:0]}, A is XORed into the upper field and ~A is XORed into the lower field.
- R5: With cfg_wide = 0, each beat is one byte taken from bus_data[7:0], and its byte index is the number of bytes already taken.
- R6: With cfg_wide = 1, each beat is two bytes. bus_data[7:0] takes the even index n and bus_data[15:8] takes index n+1.
- R7: result[11:0] holds the lower field and result[27:16] the upper field. Bits 15:12 and 31:28 are zero.
- R8: code[7:0] = result[7:0], code[15:8] = result[23:16], code[23:16] = {result[27:24], result[11:8]}.
- R9: Once 512 bytes have been taken, done is 1 and later beats change nothing until the next clear.
- R10: Dropping enable freezes the result and the count without clearing them. Accumulation resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clear | input | 1 | One-cycle clear pulse |
| cfg_enable | input | 1 | Engine enable |
| cfg_cs | input | 3 | Chip select to snoop |
| cfg_wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| bus_valid | input | 1 | Data beat strobe |
| bus_cs | input | 3 | Chip select of the current beat |
| bus_data | input | 16 | Beat data |
| result | output | 32 | Packed parity word |
| code | output | 24 | 3-byte code, byte0 in bits 7:0 |
| done | output | 1 | Sector complete |
| res_ptr | output | 4 | Result register pointer |

## Verification
Directed single-bit bytes at known indices pin the address-to-field mapping exactly, including the complement in the lower field. Full sectors of seeded random bytes in narrow and wide mode separate a wrong byte order or index from a correct one. Beats with the wrong chip select, with enable low, after done, or in the same cycle as clear show whether qualification and priority are right. A mid-sector disable followed by a resume shows that freezing keeps the state rather than losing it.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    localparam int DEF_SECTOR_BYTES = 512;
    localparam int DEF_BUS_W        = 16;
    localparam int DEF_CS_W         = 3;
    localparam int DEF_PTR_W        = 4;
    localparam int BYTE_W           = 8;
    localparam int BITSEL_W         = 3;
    localparam int HALF_W           = 16;
endpackage

// File: rtl/nand_ecc_byte_par.sv
module nand_ecc_byte_par
    import nand_ecc_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic [IDX_W-1:0]          idx,
    input  logic [BYTE_W-1:0]         dat,
    output logic [IDX_W+BITSEL_W-1:0] up_x,
    output logic [IDX_W+BITSEL_W-1:0] low_x
);
    localparam int FLD_W = IDX_W + BITSEL_W;

    always_comb begin
        up_x  = '0;
        low_x = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            if (dat[b]) begin
                up_x  = up_x ^ {idx, BITSEL_W'(b)};
                low_x = low_x ^ ~{idx, BITSEL_W'(b)};
            end
        end
    end
endmodule

// File: rtl/nand_ecc_pack.sv
module nand_ecc_pack
    import nand_ecc_pkg::*;
#(
    parameter int FLD_W = 12
) (
    input  logic [FLD_W-1:0] up_f,
    input  logic [FLD_W-1:0] low_f,
    output logic [31:0]      result,
    output logic [23:0]      code
);
    localparam int PAD_W = HALF_W - FLD_W;

    assign result = {{PAD_W{1'b0}}, up_f, {PAD_W{1'b0}}, low_f};
    assign code   = {up_f[FLD_W-1 -: 4], low_f[FLD_W-1 -: 4],
                     up_f[BYTE_W-1:0], low_f[BYTE_W-1:0]};
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = DEF_SECTOR_BYTES,
    parameter int BUS_W        = DEF_BUS_W,
    parameter int CS_W         = DEF_CS_W,
    parameter int PTR_W        = DEF_PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_clear,
    input  logic              cfg_enable,
    input  logic [CS_W-1:0]   cfg_cs,
    input  logic              cfg_wide,
    input  logic              bus_valid,
    input  logic [CS_W-1:0]   bus_cs,
    input  logic [BUS_W-1:0]  bus_data,
    output logic [31:0]       result,
    output logic [23:0]       code,
    output logic              done,
    output logic [PTR_W-1:0]  res_ptr
);
    localparam int IDX_W = $clog2(SECTOR_BYTES);
    localparam int FLD_W = IDX_W + BITSEL_W;
    localparam int CNT_W = $clog2(SECTOR_BYTES + 1);
    localparam int LANES = BUS_W / BYTE_W;

    typedef struct packed {
        logic [FLD_W-1:0] up;
        logic [FLD_W-1:0] low;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [PTR_W-1:0] ptr;
    } acc_t;

    acc_t st_q, st_d;

    logic [FLD_W-1:0] lane_up  [LANES];
    logic [FLD_W-1:0] lane_low [LANES];
    logic [LANES-1:0] lane_use;

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            logic [IDX_W-1:0] idx_l;
            logic             range_ok;
            assign idx_l    = st_q.cnt[IDX_W-1:0] + IDX_W'(l);
            assign range_ok = (st_q.cnt + CNT_W'(l)) < CNT_W'(SECTOR_BYTES);
            if (l == 0) begin : g_base
                assign lane_use[l] = range_ok;
            end else begin : g_wide
                assign lane_use[l] = range_ok && cfg_wide;
            end
            nand_ecc_byte_par #(.IDX_W(IDX_W)) u_par (
                .idx   (idx_l),
                .dat   (bus_data[l*BYTE_W +: BYTE_W]),
                .up_x  (lane_up[l]),
                .low_x (lane_low[l])
            );
        end
    endgenerate

    logic take;
    assign take = cfg_enable && bus_valid && (bus_cs == cfg_cs) && !st_q.done;

    always_comb begin
        st_d = st_q;
        if (cfg_clear) begin
            st_d     = '0;
            st_d.ptr = PTR_W'(1);
        end else if (take) begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_use[k]) begin
                    st_d.up  = st_d.up ^ lane_up[k];
                    st_d.low = st_d.low ^ lane_low[k];
                    st_d.cnt = st_d.cnt + CNT_W'(1);
                end
            end
            st_d.done = (st_d.cnt == CNT_W'(SECTOR_BYTES));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    nand_ecc_pack #(.FLD_W(FLD_W)) u_pack (
        .up_f   (st_q.up),
        .low_f  (st_q.low),
        .result (result),
        .code   (code)
    );

    assign done    = st_q.done;
    assign res_ptr = st_q.ptr;

    p_clear_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |=> (result == 32'd0) && !done && (res_ptr == PTR_W'(1)));
    p_cs_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_clear && bus_cs != cfg_cs) |=> $stable(result) && $stable(st_q.cnt));
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_clear) |=> done && $stable(result));
    p_done_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (st_q.cnt == CNT_W'(SECTOR_BYTES)));
    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !cfg_clear) |=> $stable(result) && $stable(st_q.cnt));
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(SECTOR_BYTES));
endmodule

// File: tb/nand_ecc_acc_tb.sv
`timescale 1ns/1ps
module nand_ecc_acc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_clear = 1'b0, cfg_enable = 1'b0, cfg_wide = 1'b0;
    logic [2:0]  cfg_cs = 3'd0;
    logic        bus_valid = 1'b0;
    logic [2:0]  bus_cs = 3'd0;
    logic [15:0] bus_data = 16'd0;
    logic [31:0] result;
    logic [23:0] code;
    logic        done;
    logic [3:0]  res_ptr;

    int total = 0, bad = 0;
    logic [11:0] e_up = '0, e_low = '0;
    int          e_cnt = 0;
    logic        e_done = 1'b0;
    logic [3:0]  e_ptr = '0;

    always #4 clk = ~clk;

    nand_ecc_acc u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_clear(cfg_clear), .cfg_enable(cfg_enable),
        .cfg_cs(cfg_cs), .cfg_wide(cfg_wide), .bus_valid(bus_valid), .bus_cs(bus_cs),
        .bus_data(bus_data), .result(result), .code(code), .done(done), .res_ptr(res_ptr)
    );

    function automatic logic [31:0] exp_result();
        return {4'h0, e_up, 4'h0, e_low};
    endfunction

    function automatic logic [23:0] exp_code();
        logic [31:0] r = exp_result();
        return {r[27:24], r[11:8], r[23:16], r[7:0]};
    endfunction

    task automatic model_byte(input logic [7:0] b);
        if (e_cnt < 512) begin
            for (int i = 0; i < 8; i++) begin
                if (b[i]) begin
                    logic [11:0] a = {e_cnt[8:0], i[2:0]};
                    e_up  = e_up ^ a;
                    e_low = e_low ^ ~a;
                end
            end
            e_cnt++;
        end
    endtask

    task automatic chk(input string tag);
        total++;
        if (result !== exp_result() || code !== exp_code() || done !== e_done || res_ptr !== e_ptr) begin
            bad++;
            $display("FAIL %s: result=%h code=%h done=%b ptr=%h expected result=%h code=%h done=%b ptr=%h",
                     tag, result, code, done, res_ptr, exp_result(), exp_code(), e_done, e_ptr);
        end
    endtask

    task automatic beat(input logic [2:0] cs, input logic [15:0] d);
        bus_valid = 1'b1; bus_cs = cs; bus_data = d;
        @(posedge clk);
        if (cfg_clear) begin
            e_up = '0; e_low = '0; e_cnt = 0; e_done = 1'b0; e_ptr = 4'd1;
        end else if (cfg_enable && cs == cfg_cs && !e_done) begin
            model_byte(d[7:0]);
            if (cfg_wide) model_byte(d[15:8]);
            e_done = (e_cnt == 512);
        end
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic clear_pulse();
        cfg_clear = 1'b1;
        beat(cfg_cs ^ 3'd1, 16'h0);
        cfg_clear = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: expired expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset state");
        rst_n = 1'b1;
        cfg_cs = 3'd5; cfg_enable = 1'b1;
        @(negedge clk);
        clear_pulse();
        chk("R2 clear sets pointer");

        // R4 R7 R8: single bit at index 0 bit 0
        beat(3'd5, 16'h0001);
        chk("R4 R7 R8 single bit byte0");
        // R4: bit 7 at index 1
        beat(3'd5, 16'h0080);
        chk("R4 bit7 index1");
        // R3: wrong cs and enable low
        beat(3'd2, 16'h00FF);
        chk("R3 cs mismatch ignored");
        cfg_enable = 1'b0;
        beat(3'd5, 16'h00FF);
        chk("R3 R10 disabled ignored");
        cfg_enable = 1'b1;
        beat(3'd5, 16'h0055);
        chk("R10 resume after freeze");

        // R5 R9: rest of sector narrow random
        while (e_cnt < 512) begin
            beat(3'd5, 16'($urandom()));
            if (e_cnt % 64 == 0) chk("R5 narrow random");
        end
        chk("R9 done after 512 narrow");
        beat(3'd5, 16'hFFFF);
        chk("R9 beat after done ignored");

        // R2: beat in clear cycle dropped
        cfg_clear = 1'b1;
        beat(3'd5, 16'h00FF);
        cfg_clear = 1'b0;
        chk("R2 clear beats same cycle beat");

        // R6: wide mode random sector
        cfg_wide = 1'b1;
        beat(3'd5, 16'h0100);
        chk("R6 high byte odd index");
        while (e_cnt < 512) begin
            beat(3'd5, 16'($urandom()));
            if (e_cnt % 128 == 0) chk("R6 wide random");
        end
        chk("R6 R9 done after wide sector");

        // R10 mid-sector freeze in wide mode, new cs
        clear_pulse();
        cfg_cs = 3'd3;
        for (int i = 0; i < 20; i++) beat(3'd3, 16'($urandom()));
        cfg_enable = 1'b0;
        for (int i = 0; i < 5; i++) beat(3'd3, 16'($urandom()));
        chk("R10 frozen while disabled");
        cfg_enable = 1'b1;
        for (int i = 0; i < 5; i++) beat(3'd3, 16'($urandom()));
        chk("R10 R3 resumed");

        // R4 erased sector: all ones wide
        clear_pulse();
        while (e_cnt < 512) beat(3'd3, 16'hFFFF);
        chk("R4 R9 all ones sector");
        clear_pulse();
        chk("R2 clear after done");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule